// File: doc/BRIEF.md
# Paged Host Register Interface

This block is the host-facing slave port of a time-slot switch. A processor sees it as a small memory peripheral: a 6-bit address, an 8-bit data bus split into input, output and output-enable, an active-high strobe, a read/write select (high means read), an active-low chip select, and an acknowledge that is pulled low when the access is done. The host strobes are asynchronous. They pass through synchronizers before the block acts on them. The address and write data are expected to be stable while the strobe is high.

A control register sets the page for memory accesses. It picks the target memory (data memory, low connection memory or high connection memory) and one of eight streams. The five low address bits then pick a channel inside that page. A split mode sends reads to the data memory and writes to the low connection memory, whatever the select field holds. A broadcast bit is passed through to the switching datapath. Memory accesses reach the shared memories only in cycles where the datapath reports that it is not using them. Each host access produces at most one memory request.

Top module: `hpg_host_port`

## Requirements
- R1: When address bit 5 is 0, the access goes to the control register, whatever bits 4:0 hold. A read through any such address returns the 8-bit value last written through any such address.
- R2: When address bit 5 is 1, the access goes to the channel given by address bits 4:0. The page is the stream in control bits 2:0 and the memory in control bits 4:3, coded 01 data, 10 low connection, 11 high connection. The request address is stream*32 + channel.
- R3: Control bit 6 appears on `bcast_mode` as soon as the control write completes.
- R4: When control bit 7 is 1, reads come from the data memory and writes go to the low connection memory, whatever bits 4:3 hold.
- R5: A write aimed at the data memory issues no memory request and leaves the data memory unchanged. It is still acknowledged.
- R6: With select code 00 and split off, a read returns 0x00 and a write changes no memory. Both are acknowledged.
- R7: A memory request is issued only in a cycle where `dp_busy` is 0. Each host access issues no more than one request.
- R8: `host_ack_lo` rises within 40 clocks of the strobe rising, as long as the datapath leaves a free cycle at least every 4 clocks. It falls within 5 clocks after the strobe or the chip select goes inactive.
- R9: `host_d_oe` is 1 only while `host_cs_n` is 0, `host_ds` is 1 and `host_rd_wr` is 1. During a read acknowledge, `host_d_o` holds the value read.
- R10: After reset, `host_ack_lo`, `host_d_oe`, `mem_req` and `bcast_mode` are 0, and the control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Chip select, active low |
| host_ds | input | 1 | Data strobe, active high |
| host_rd_wr | input | 1 | 1 = read, 0 = write |
| host_addr | input | 6 | Host address |
| host_d_i | input | 8 | Host write data |
| host_d_o | output | 8 | Host read data |
| host_d_oe | output | 1 | Drive enable for host data |
| host_ack_lo | output | 1 | 1 pulls the open-drain acknowledge low |
| dp_busy | input | 1 | Datapath is using the memories this cycle |
| mem_req | output | 1 | Memory access strobe, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_sel | output | 2 | Target memory: 01 data, 10 low conn, 11 high conn |
| mem_addr | output | 8 | Stream*32 + channel |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| bcast_mode | output | 1 | Broadcast mode bit for the datapath |

## Verification
The bench writes every channel of every stream in both connection memories and reads every location of all three memories back. A wrong stream or channel concatenation would return another location's value, and a swapped select code would return data from the wrong memory. Split mode is run with the select field set to high connection memory. A design that honoured the field would corrupt that memory instead of the low one, or would read from a connection memory instead of the data memory. Writes aimed at the data memory and accesses with select code 00 are each followed by read-back of the locations they could have changed. The datapath stays busy three cycles out of four, so a request that ignored the busy input, a second request per access, a slow acknowledge or a slow release would all show.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_DATA = 2'b01,
    SEL_CLO  = 2'b10,
    SEL_CHI  = 2'b11
  } msel_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RDAT,
    ST_ACK
  } hstate_e;
endpackage

// File: rtl/hpg_rst_sync.sv
module hpg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] rs_q;
  logic [1:0] rs_d;

  always_comb rs_d = {rs_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= rs_d;
  end

  assign rst_s_n = rs_q[1];
endmodule

// File: rtl/hpg_sync.sv
module hpg_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain_q;
  logic [STAGES-1:0][W-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/hpg_ctlreg.sv
module hpg_ctlreg
  import hpg_pkg::*;
#(
  parameter int DW = 8,
  parameter int STR_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             op_rd,
  output logic [DW-1:0]    ctl_q,
  output logic [STR_W-1:0] stream,
  output msel_e            msel,
  output logic             bcast
);
  localparam int SEL_LO = STR_W;
  localparam int SEL_HI = STR_W + 1;
  localparam int BC_BIT = DW - 2;
  localparam int SP_BIT = DW - 1;

  logic [DW-1:0] ctl_d;

  always_comb ctl_d = wr_en ? wdata : ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    if (ctl_q[SP_BIT]) msel = op_rd ? SEL_DATA : SEL_CLO;
    else               msel = msel_e'(ctl_q[SEL_HI:SEL_LO]);
  end

  assign stream = ctl_q[STR_W-1:0];
  assign bcast  = ctl_q[BC_BIT];
endmodule

// File: rtl/hpg_fsm.sv
module hpg_fsm
  import hpg_pkg::*;
#(
  parameter int DW = 8,
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc,
  input  logic            rd_wr_s,
  input  logic [CH_W:0]   addr,
  input  logic [DW-1:0]   wdata_in,
  input  msel_e           msel,
  input  logic            dp_busy,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [DW-1:0]   ctl_q,
  output logic            ctl_we,
  output logic            op_rd,
  output logic [CH_W-1:0] ch_q,
  output logic [DW-1:0]   wdata_q,
  output logic            mem_req,
  output logic            mem_we,
  output logic            ack,
  output logic [DW-1:0]   rd_q
);
  hstate_e         state_q, state_d;
  logic            lat_en;
  logic            drop;
  logic [DW-1:0]   rd_d;
  logic            op_rd_d;
  logic [CH_W-1:0] ch_d;
  logic [DW-1:0]   wdata_d;

  always_comb drop = (msel == SEL_NONE) || (!op_rd && msel == SEL_DATA);

  always_comb begin
    state_d = state_q;
    ctl_we  = 1'b0;
    mem_req = 1'b0;
    lat_en  = 1'b0;
    rd_d    = rd_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc) begin
          lat_en = 1'b1;
          if (!addr[CH_W]) begin
            if (rd_wr_s) rd_d = ctl_q;
            else         ctl_we = 1'b1;
            state_d = ST_ACK;
          end else begin
            state_d = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (drop) begin
          if (op_rd) rd_d = '0;
          state_d = ST_ACK;
        end else if (!dp_busy) begin
          mem_req = 1'b1;
          state_d = op_rd ? ST_RDAT : ST_ACK;
        end
      end
      ST_RDAT: begin
        rd_d    = mem_rdata;
        state_d = ST_ACK;
      end
      ST_ACK: begin
        if (!acc) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    op_rd_d = lat_en ? rd_wr_s          : op_rd;
    ch_d    = lat_en ? addr[CH_W-1:0]   : ch_q;
    wdata_d = lat_en ? wdata_in         : wdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_rd   <= 1'b0;
      ch_q    <= '0;
      wdata_q <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      op_rd   <= op_rd_d;
      ch_q    <= ch_d;
      wdata_q <= wdata_d;
      rd_q    <= rd_d;
    end
  end

  assign mem_we = mem_req && !op_rd;
  assign ack    = (state_q == ST_ACK);

  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !acc) |=> !ack);
endmodule

// File: rtl/hpg_host_port.sv
module hpg_host_port
  import hpg_pkg::*;
#(
  parameter int DW = 8,
  parameter int CH_W = 5,
  parameter int STR_W = 3,
  parameter int SYNC_STAGES = 2,
  localparam int HOST_AW = CH_W + 1,
  localparam int MEM_AW = STR_W + CH_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_cs_n,
  input  logic               host_ds,
  input  logic               host_rd_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [DW-1:0]      host_d_i,
  output logic [DW-1:0]      host_d_o,
  output logic               host_d_oe,
  output logic               host_ack_lo,
  input  logic               dp_busy,
  output logic               mem_req,
  output logic               mem_we,
  output logic [1:0]         mem_sel,
  output logic [MEM_AW-1:0]  mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata,
  output logic               bcast_mode
);
  logic             rst_s_n;
  logic [2:0]       strb_s;
  logic             acc;
  logic             ctl_we;
  logic             op_rd;
  logic [CH_W-1:0]  ch_q;
  logic [DW-1:0]    ctl_q;
  logic [STR_W-1:0] stream;
  msel_e            msel;

  hpg_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  hpg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_s_n),
    .d     ({host_cs_n, host_ds, host_rd_wr}),
    .q     (strb_s)
  );

  assign acc = !strb_s[2] && strb_s[1];

  hpg_ctlreg #(.DW(DW), .STR_W(STR_W)) u_ctl (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .wr_en  (ctl_we),
    .wdata  (host_d_i),
    .op_rd  (op_rd),
    .ctl_q  (ctl_q),
    .stream (stream),
    .msel   (msel),
    .bcast  (bcast_mode)
  );

  hpg_fsm #(.DW(DW), .CH_W(CH_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .acc       (acc),
    .rd_wr_s   (strb_s[0]),
    .addr      (host_addr),
    .wdata_in  (host_d_i),
    .msel      (msel),
    .dp_busy   (dp_busy),
    .mem_rdata (mem_rdata),
    .ctl_q     (ctl_q),
    .ctl_we    (ctl_we),
    .op_rd     (op_rd),
    .ch_q      (ch_q),
    .wdata_q   (mem_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .ack       (host_ack_lo),
    .rd_q      (host_d_o)
  );

  assign mem_sel   = msel;
  assign mem_addr  = {stream, ch_q};
  assign host_d_oe = !host_cs_n && host_ds && host_rd_wr;

  // R7
  req_free_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req |-> !dp_busy);

  // R7
  req_once_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    mem_req |=> !mem_req);

  // R5
  no_dmem_wr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && mem_we) |-> (mem_sel != SEL_DATA));

  // R4
  split_wr_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && mem_we && ctl_q[DW-1]) |-> (mem_sel == SEL_CLO));
endmodule

// File: tb/hpg_host_port_tb_top.sv
module hpg_host_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       host_cs_n, host_ds, host_rd_wr;
  logic [5:0] host_addr;
  logic [7:0] host_d_i, host_d_o;
  logic       host_d_oe, host_ack_lo;
  logic       dp_busy;
  logic       mem_req, mem_we;
  logic [1:0] mem_sel;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       bcast_mode;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int bad_req = 0;
  int cyc = 0;
  bit done = 0;

  logic [7:0] dmem [256];
  logic [7:0] clo  [256];
  logic [7:0] chi  [256];

  always #2 clk = ~clk;

  hpg_host_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_ds(host_ds),
    .host_rd_wr(host_rd_wr), .host_addr(host_addr), .host_d_i(host_d_i),
    .host_d_o(host_d_o), .host_d_oe(host_d_oe), .host_ack_lo(host_ack_lo),
    .dp_busy(dp_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .bcast_mode(bcast_mode)
  );

  // Memory and datapath environment: busy three cycles out of four
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req) begin
      req_cnt <= req_cnt + 1;
      if (dp_busy) bad_req <= bad_req + 1;
      if (mem_we) begin
        case (mem_sel)
          2'b01: dmem[mem_addr] <= mem_wdata;
          2'b10: clo[mem_addr]  <= mem_wdata;
          2'b11: chi[mem_addr]  <= mem_wdata;
          default: ;
        endcase
      end else begin
        case (mem_sel)
          2'b01: mem_rdata <= dmem[mem_addr];
          2'b10: mem_rdata <= clo[mem_addr];
          2'b11: mem_rdata <= chi[mem_addr];
          default: mem_rdata <= 8'hXX;
        endcase
      end
    end
  end
  assign dp_busy = (cyc % 4) != 3;

  function automatic logic [7:0] dm_val(int i);
    return 8'((i * 7 + 3) & 255);
  endfunction
  function automatic logic [7:0] clo_val(int s, int c);
    return 8'(((s * 32 + c) ^ 8'h5A) & 255);
  endfunction
  function automatic logic [7:0] chi_val(int s, int c);
    return 8'(((s * 32 + c) * 3 + 1) & 255);
  endfunction

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic host_acc(input bit rd, input logic [5:0] a, input logic [7:0] wd,
                          output logic [7:0] rdv);
    int n;
    @(negedge clk);
    host_addr = a; host_rd_wr = rd; host_d_i = wd; host_cs_n = 1'b0;
    @(negedge clk);
    host_ds = 1'b1;
    n = 0;
    while (!host_ack_lo && n < 60) begin
      @(negedge clk);
      n++;
    end
    chk(n <= 40, "R8 ack latency", n, 40);
    chk(host_d_oe == rd, "R9 oe during access", int'(host_d_oe), int'(rd));
    rdv = host_d_o;
    @(negedge clk);
    host_ds = 1'b0; host_cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(host_ack_lo == 1'b0, "R8 ack release", int'(host_ack_lo), 0);
    chk(host_d_oe == 1'b0, "R9 oe after access", int'(host_d_oe), 0);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] v);
    logic [7:0] dummy;
    host_acc(1'b0, a, v, dummy);
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [7:0] exp, input string what);
    logic [7:0] v;
    host_acc(1'b1, a, 8'h00, v);
    chk(v == exp, what, int'(v), int'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < 256; i++) begin
      dmem[i] = dm_val(i);
      clo[i] = 8'h00;
      chi[i] = 8'h00;
    end
    mem_rdata = 8'h00;
    rst_n = 1'b0; host_cs_n = 1'b1; host_ds = 1'b0; host_rd_wr = 1'b1;
    host_addr = 6'h00; host_d_i = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    chk(host_ack_lo == 1'b0, "R10 ack after reset", int'(host_ack_lo), 0);
    chk(mem_req == 1'b0, "R10 req after reset", int'(mem_req), 0);
    chk(bcast_mode == 1'b0, "R10 bcast after reset", int'(bcast_mode), 0);
    chk(host_d_oe == 1'b0, "R10 oe after reset", int'(host_d_oe), 0);
    rd_chk(6'h00, 8'h00, "R10 control reads zero");

    // R9 strobe and read without chip select: no drive, no access
    @(negedge clk);
    host_rd_wr = 1'b1; host_ds = 1'b1; host_cs_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(host_d_oe == 1'b0, "R9 oe without cs", int'(host_d_oe), 0);
    chk(host_ack_lo == 1'b0, "R9 no ack without cs", int'(host_ack_lo), 0);
    host_ds = 1'b0;

    // R1 control register reachable from every low address; R3 broadcast bit
    for (int lo = 0; lo < 32; lo++) begin
      logic [7:0] v;
      v = 8'((lo * 37 + 11) & 255);
      wr(6'(lo), v);
      chk(bcast_mode == v[6], "R3 bcast bit", int'(bcast_mode), int'(v[6]));
      rd_chk(6'(31 - lo), v, "R1 control readback");
    end

    // R2 full sweep of both connection memories and the data memory
    for (int s = 0; s < 8; s++) begin
      wr(6'h00, 8'(8'h10 | s));
      for (int c = 0; c < 32; c++) wr(6'(32 + c), clo_val(s, c));
      wr(6'h00, 8'(8'h18 | s));
      for (int c = 0; c < 32; c++) wr(6'(32 + c), chi_val(s, c));
    end
    for (int s = 0; s < 8; s++) begin
      wr(6'h00, 8'(8'h08 | s));
      for (int c = 0; c < 32; c++) rd_chk(6'(32 + c), dm_val(s * 32 + c), "R2 data memory read");
      wr(6'h00, 8'(8'h10 | s));
      for (int c = 0; c < 32; c++) rd_chk(6'(32 + c), clo_val(s, c), "R2 low conn read");
      wr(6'h00, 8'(8'h18 | s));
      for (int c = 0; c < 32; c++) rd_chk(6'(32 + c), chi_val(s, c), "R2 high conn read");
    end

    // R7 exactly one request per memory access
    wr(6'h00, 8'h13);
    r0 = req_cnt;
    rd_chk(6'd40, clo_val(3, 8), "R7 read value");
    chk(req_cnt - r0 == 1, "R7 one request per access", req_cnt - r0, 1);

    // R4 split mode with select field pointing at high connection memory
    wr(6'h00, 8'h9D);
    wr(6'(32 + 7), 8'hC3);
    rd_chk(6'(32 + 7), dm_val(5 * 32 + 7), "R4 split read from data memory");
    wr(6'h00, 8'h15);
    rd_chk(6'(32 + 7), 8'hC3, "R4 split write landed in low conn");
    wr(6'h00, 8'h1D);
    rd_chk(6'(32 + 7), chi_val(5, 7), "R4 high conn untouched");

    // R5 write to data memory is discarded
    wr(6'h00, 8'h0A);
    r0 = req_cnt;
    wr(6'(32 + 9), 8'hEE);
    chk(req_cnt - r0 == 0, "R5 no request for data write", req_cnt - r0, 0);
    rd_chk(6'(32 + 9), dm_val(2 * 32 + 9), "R5 data memory unchanged");
    wr(6'h00, 8'h12);
    rd_chk(6'(32 + 9), clo_val(2, 9), "R5 low conn unchanged");

    // R6 select code 00
    wr(6'h00, 8'h03);
    rd_chk(6'(32 + 4), 8'h00, "R6 none select reads zero");
    r0 = req_cnt;
    wr(6'(32 + 4), 8'h11);
    chk(req_cnt - r0 == 0, "R6 no request for none write", req_cnt - r0, 0);
    wr(6'h00, 8'h13);
    rd_chk(6'(32 + 4), clo_val(3, 4), "R6 low conn unchanged");
    wr(6'h00, 8'h1B);
    rd_chk(6'(32 + 4), chi_val(3, 4), "R6 high conn unchanged");

    // R7 no request during a busy cycle over the whole run
    chk(bad_req == 0, "R7 requests in busy cycles", bad_req, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule